// File: doc/BRIEF.md
# I2C Slave Transmitter with Status Codes

This block is the transmit half of an I2C target. It watches the bus lines, spots START and STOP conditions, and compares the first byte after a START against its own 7-bit address. When that byte names the block and carries the read direction, the block acknowledges it. It then reports each step of the transfer as an 8-bit status code together with an interrupt flag (SI). While SI is set, the block holds SCL low, so the bus waits for the host.

The host supplies each outgoing byte over a valid/ready stream. `tx_ready` is high only while SI is set in one of the three codes that ask for data. A handshake (`tx_valid && tx_ready` at a rising clock edge) does three things: it loads the byte, it clears SI, and it releases SCL. Back-pressure is simple. If the host keeps `tx_valid` low, SCL stays low for as long as it likes, and no bus timing is lost.

The acknowledge-enable input `ack_en` is sampled when a byte is loaded. If it is low at that point, the byte becomes the final one. After the final byte, or after a NACK from the master, SI is cleared through `si_clr`. The block then lets SDA float, so a master that keeps clocking reads ones. While `ack_en` stays low, the block ignores its own address, but it keeps tracking START and STOP. Raising `ack_en` again restores address recognition. The bus inputs are the wired-AND line levels and pass through a `SYNC_STAGES`-deep synchronizer. The pad drivers are open-drain enables.

Top module: `i2c_slv_tx_status`

## Requirements
- R1: After reset, SI is 0, the status is 0xF8, `sda_oe`, `scl_oe` and `tx_ready` are 0. Whenever SI is 0 the status reads 0xF8.
- R2: An address byte whose upper seven bits equal `own_addr` and whose eighth bit (read) is 1, received with `ack_en` high, is acknowledged: SDA is pulled low for the ninth clock. After the ninth SCL falling edge, SI is set with status 0xA8, and SCL is held low while SI is 1.
- R3: If `arb_lost` is high when that address byte completes, the status reported is 0xB0 instead of 0xA8. All other behaviour is the same.
- R4: An address that differs, or the own address with the write bit (0), gets no acknowledge and no SI. Clocks that follow read as ones until the next START.
- R5: `tx_ready` is 1 only while SI is set with status 0xA8, 0xB0 or 0xB8. A handshake clears SI (status back to 0xF8) and releases SCL. Without `tx_valid`, SCL stays held.
- R6: Data bytes are sent MSB first, and `sda_oe` only changes while SCL is low.
- R7: A byte loaded with `ack_en` high and acknowledged by the master (SDA low on the ninth rising edge) gives status 0xB8.
- R8: A byte that the master does not acknowledge gives status 0xC0, and the block leaves the addressed state.
- R9: A byte loaded with `ack_en` low is the last one. If the master acknowledges it, the status is 0xC8, and the block leaves the addressed state.
- R10: In status 0xC0 or 0xC8, `si_clr` clears SI and SDA stays released. Further bytes clocked by the master read 0xFF.
- R11: With `ack_en` low, the own address with the read bit is not acknowledged and SI stays 0. Raising `ack_en` lets the next such address be acknowledged again.
- R12: A START in the middle of a byte restarts address matching at once. A STOP in the middle of a byte returns the block to idle with SDA released.
- R13: `si_clr` has no effect while the status is 0xA8, 0xB0 or 0xB8. Only a data handshake ends that hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (held while SI is set) |
| sda_oe | output | 1 | Pull SDA low |
| own_addr | input | 7 | Own 7-bit target address |
| ack_en | input | 1 | Acknowledge enable; low makes the next loaded byte the last and disables address response |
| arb_lost | input | 1 | High when the address arrives after arbitration was lost as master |
| tx_data | input | 8 | Outgoing byte |
| tx_valid | input | 1 | Outgoing byte is valid |
| tx_ready | output | 1 | Block accepts a byte this cycle |
| si_clr | input | 1 | Clear SI in the end-of-transfer codes |
| si | output | 1 | Interrupt flag |
| status | output | 8 | Status code |

## Verification
The bench goes after the acknowledge-enable timing. It drops `ack_en` at the load of a middle byte and expects 0xC8 followed by a 0xFF readback. A design that sampled it late would report 0xB8 and keep driving data. It also aborts data bytes with a repeated START and with a STOP. A design that missed either would go on shifting, and its next status code or its released SDA would be wrong. Finally, it pulses `si_clr` while a data byte is still owed and stalls `tx_valid`. A design that freed SCL early would let the master read garbage, and the per-cycle status comparison would catch the stray code.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_HOLD, ST_TX, ST_TACK, ST_END
  } st_e;

  localparam logic [7:0] STS_NONE      = 8'hF8;
  localparam logic [7:0] STS_ADDR_RD   = 8'hA8;
  localparam logic [7:0] STS_ARB_RD    = 8'hB0;
  localparam logic [7:0] STS_DATA_ACK  = 8'hB8;
  localparam logic [7:0] STS_DATA_NACK = 8'hC0;
  localparam logic [7:0] STS_LAST_ACK  = 8'hC8;
endpackage

// File: rtl/i2cst_bus_mon.sv
module i2cst_bus_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_s;
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh[0] <= scl_in;
          sda_sh[0] <= sda_in;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            scl_sh[i] <= scl_sh[i-1];
            sda_sh[i] <= sda_sh[i-1];
          end
        end
      end
      assign scl_s = scl_sh[SYNC_STAGES-1];
      assign sda_s = sda_sh[SYNC_STAGES-1];
    end else begin : g_direct
      assign scl_s = scl_in;
      assign sda_s = sda_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cst_addr_match.sv
module i2cst_addr_match #(
  parameter int AW = 7
) (
  input  logic [AW:0]   rx_byte,
  input  logic [AW-1:0] own_addr,
  input  logic          ack_en,
  output logic          hit
);
  // read direction in bit 0, address in the bits above it
  assign hit = ack_en && rx_byte[0] && (rx_byte[AW:1] == own_addr);
endmodule

// File: rtl/i2c_slv_tx_status.sv
module i2c_slv_tx_status
  import i2cst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              arb_lost,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              si_clr,
  output logic              si,
  output logic [7:0]        status
);
  localparam int BW = BYTE_W;
  localparam int CW = $clog2(BW + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic hit;
  st_e  st;
  logic [BW-1:0] sreg;
  logic [BW-1:0] rx_byte;
  logic [CW-1:0] cnt;
  logic last_q, nack_q, arb_q;
  logic take;

  i2cst_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign rx_byte = {sreg[BW-2:0], sda_s};

  i2cst_addr_match #(.AW(ADDR_W)) u_match (
    .rx_byte(rx_byte), .own_addr(own_addr), .ack_en(ack_en), .hit(hit)
  );

  assign tx_ready = si & (st == ST_HOLD);
  assign scl_oe   = si;
  assign take     = tx_valid & tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sreg   <= '0;
      cnt    <= '0;
      last_q <= 1'b0;
      nack_q <= 1'b0;
      arb_q  <= 1'b0;
      sda_oe <= 1'b0;
      si     <= 1'b0;
      status <= STS_NONE;
    end else if (start_det) begin
      st     <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
      si     <= 1'b0;
      status <= STS_NONE;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
      si     <= 1'b0;
      status <= STS_NONE;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_ADDR: if (scl_rise) begin
          sreg <= rx_byte;
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(BW - 1)) begin
            st    <= hit ? ST_AACK : ST_IDLE;
            arb_q <= arb_lost;
          end
        end
        ST_AACK: if (scl_fall) begin
          if (!sda_oe) sda_oe <= 1'b1;
          else begin
            sda_oe <= 1'b0;
            si     <= 1'b1;
            status <= arb_q ? STS_ARB_RD : STS_ADDR_RD;
            st     <= ST_HOLD;
          end
        end
        ST_HOLD: if (take) begin
          sreg   <= tx_data;
          sda_oe <= ~tx_data[BW-1];
          last_q <= ~ack_en;
          cnt    <= '0;
          si     <= 1'b0;
          status <= STS_NONE;
          st     <= ST_TX;
        end
        ST_TX: begin
          if (scl_rise) cnt <= cnt + 1'b1;
          else if (scl_fall) begin
            if (cnt == CW'(BW)) begin
              sda_oe <= 1'b0;
              st     <= ST_TACK;
            end else begin
              sda_oe <= ~sreg[BW-2];
              sreg   <= {sreg[BW-2:0], 1'b0};
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) nack_q <= sda_s;
          else if (scl_fall) begin
            si <= 1'b1;
            if (nack_q) begin
              status <= STS_DATA_NACK;
              st     <= ST_END;
            end else if (last_q) begin
              status <= STS_LAST_ACK;
              st     <= ST_END;
            end else begin
              status <= STS_DATA_ACK;
              st     <= ST_HOLD;
            end
          end
        end
        ST_END: if (si_clr && si) begin
          si     <= 1'b0;
          status <= STS_NONE;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cst_chk.sv
module i2cst_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       si_clr,
  input logic       si,
  input logic [7:0] status
);
  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !si |-> status == 8'hF8);
  // R5
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> si);
  // R5
  handoff_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!si && !scl_oe));
  // R6
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);
  // R2
  flag_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> !scl_in);
  // R2
  valid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> (status == 8'hA8 || status == 8'hB0 || status == 8'hB8 ||
                   status == 8'hC0 || status == 8'hC8));
  // R10
  end_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si && (status == 8'hC0 || status == 8'hC8)) |-> !sda_oe);
  // R13
  clr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si && tx_ready && si_clr && !tx_valid) |=> si);
endmodule

bind i2c_slv_tx_status i2cst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .si_clr(si_clr), .si(si), .status(status)
);

// File: tb/i2c_slv_tx_status_tb.sv
module i2c_slv_tx_status_tb;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_line, sda_line;
  logic scl_oe, sda_oe, tx_ready, si;
  logic [7:0] status;
  logic ack_en = 1'b1, arb_lost = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0, si_clr = 1'b0;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2c_slv_tx_status u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .ack_en(ack_en),
    .arb_lost(arb_lost), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .si_clr(si_clr), .si(si), .status(status)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] data_q[$];
  bit aa_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // reference status model: no SI means the idle code, every clock
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!si) chk(status == 8'hF8, "R1 idle code while SI low", status, 8'hF8);
      if (sda_oe != prev_oe && scl_line && prev_scl)
        chk(0, "R6 SDA drive changed with SCL high", sda_oe, prev_oe);
    end
    prev_oe  = sda_oe;
    prev_scl = scl_line;
  end

  // host: expects each SI in order, feeds bytes, clears end codes
  initial begin : host
    logic [7:0] cur;
    forever begin
      @(negedge clk);
      if (rst_n && si) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4/R11 unexpected SI", status, 8'hF8);
          cur = 8'h00;
        end else begin
          cur = exp_q.pop_front();
          chk(status == cur, "R2/R7 status code at SI", status, cur);
        end
        repeat (3) @(negedge clk);
        if (cur == 8'hA8 || cur == 8'hB0 || cur == 8'hB8) begin
          si_clr = 1'b1;
          @(negedge clk);
          si_clr = 1'b0;
          @(negedge clk);
          chk(si == 1'b1 && status == cur, "R13 clear ignored while byte owed", status, cur);
          repeat (2) @(negedge clk);
          chk(scl_line == 1'b0, "R5 SCL held while no data", scl_line, 0);
          chk(tx_ready == 1'b1, "R5 ready while byte owed", tx_ready, 1);
          ack_en   = (aa_q.size() != 0) ? aa_q.pop_front() : 1'b1;
          tx_data  = (data_q.size() != 0) ? data_q.pop_front() : 8'hFF;
          tx_valid = 1'b1;
          @(negedge clk);
          tx_valid = 1'b0;
          chk(si == 1'b0 && status == 8'hF8, "R5 handshake clears SI", status, 8'hF8);
        end else begin
          si_clr = 1'b1;
          @(negedge clk);
          si_clr = 1'b0;
          chk(si == 1'b0 && status == 8'hF8, "R10 clear after end code", status, 8'hF8);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  task automatic q_wait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    q_wait();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q_wait();
    scl_high();
    m_sda = 1'b0; q_wait();
    m_scl = 1'b0; q_wait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q_wait();
    scl_high();
    m_sda = 1'b1; q_wait();
  endtask

  task automatic bus_bit(input bit b, output bit r);
    m_sda = b; q_wait();
    scl_high();
    r = sda_line;
    m_scl = 1'b0; q_wait();
  endtask

  task automatic send_addr(input logic [6:0] a, input bit rw, output bit ack);
    bit r;
    for (int i = 6; i >= 0; i--) bus_bit(a[i], r);
    bus_bit(rw, r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] d);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      d[i] = r;
    end
    bus_bit(~give_ack, r);
  endtask

  initial begin : main
    bit ack, r;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    // R1
    chk(si == 0 && status == 8'hF8, "R1 reset status", status, 8'hF8);
    chk(!sda_oe && !scl_oe && !tx_ready, "R1 reset drivers", {sda_oe, scl_oe, tx_ready}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R6 R7 R8: three bytes, last one NACKed
    exp_q = '{8'hA8, 8'hB8, 8'hB8, 8'hC0};
    data_q = '{8'hA5, 8'h3C, 8'h81};
    aa_q = '{1'b1, 1'b1, 1'b1};
    bus_start();
    send_addr(OWN, 1'b1, ack);
    chk(ack, "R2 own read address acknowledged", ack, 1);
    read_byte(1'b1, d); chk(d == 8'hA5, "R6 first byte MSB first", d, 8'hA5);
    read_byte(1'b1, d); chk(d == 8'h3C, "R7 second byte", d, 8'h3C);
    read_byte(1'b0, d); chk(d == 8'h81, "R8 NACKed byte", d, 8'h81);
    bus_stop();
    chk(exp_q.size() == 0, "R8 all codes seen", exp_q.size(), 0);

    // R9 R10: ack_en dropped at second load
    exp_q = '{8'hA8, 8'hB8, 8'hC8};
    data_q = '{8'h12, 8'h34};
    aa_q = '{1'b1, 1'b0};
    bus_start();
    send_addr(OWN, 1'b1, ack);
    read_byte(1'b1, d); chk(d == 8'h12, "R9 byte before last", d, 8'h12);
    read_byte(1'b1, d); chk(d == 8'h34, "R9 last byte", d, 8'h34);
    read_byte(1'b1, d); chk(d == 8'hFF, "R10 reads ones after last", d, 8'hFF);
    bus_stop();
    chk(exp_q.size() == 0, "R9 codes incl C8 seen", exp_q.size(), 0);

    // R11: ack_en is low now
    bus_start();
    send_addr(OWN, 1'b1, ack);
    chk(!ack, "R11 no ack with ack_en low", ack, 0);
    bus_stop();
    chk(si == 0, "R11 no SI with ack_en low", si, 0);
    ack_en = 1'b1;
    exp_q = '{8'hA8, 8'hC0};
    data_q = '{8'hC3};
    aa_q = '{1'b1};
    bus_start();
    send_addr(OWN, 1'b1, ack);
    chk(ack, "R11 resumes after ack_en set", ack, 1);
    read_byte(1'b0, d); chk(d == 8'hC3, "R11 data after resume", d, 8'hC3);
    bus_stop();

    // R4: foreign address and own write
    bus_start();
    send_addr(OWN ^ 7'h01, 1'b1, ack);
    chk(!ack, "R4 foreign address ignored", ack, 0);
    read_byte(1'b1, d); chk(d == 8'hFF, "R4 bus reads ones", d, 8'hFF);
    bus_stop();
    bus_start();
    send_addr(OWN, 1'b0, ack);
    chk(!ack, "R4 own write ignored", ack, 0);
    bus_stop();

    // R3: arbitration lost flavour
    arb_lost = 1'b1;
    exp_q = '{8'hB0, 8'hC0};
    data_q = '{8'h6E};
    aa_q = '{1'b1};
    bus_start();
    send_addr(OWN, 1'b1, ack);
    arb_lost = 1'b0;
    read_byte(1'b0, d); chk(d == 8'h6E, "R3 data after B0", d, 8'h6E);
    bus_stop();
    chk(exp_q.size() == 0, "R3 B0 code seen", exp_q.size(), 0);

    // R12: repeated START mid-byte, then STOP mid-byte
    exp_q = '{8'hA8, 8'hA8, 8'hC0};
    data_q = '{8'hFF, 8'h99};
    aa_q = '{1'b1, 1'b1};
    bus_start();
    send_addr(OWN, 1'b1, ack);
    for (int i = 0; i < 4; i++) bus_bit(1'b1, r);
    bus_start();
    send_addr(OWN, 1'b1, ack);
    chk(ack, "R12 address after repeated start", ack, 1);
    read_byte(1'b0, d); chk(d == 8'h99, "R12 byte after restart", d, 8'h99);
    bus_stop();
    exp_q = '{8'hA8};
    data_q = '{8'hFF};
    aa_q = '{1'b1};
    bus_start();
    send_addr(OWN, 1'b1, ack);
    for (int i = 0; i < 3; i++) bus_bit(1'b1, r);
    bus_stop();
    repeat (20) @(negedge clk);
    chk(!sda_oe && !si, "R12 idle after stop abort", {sda_oe, si}, 0);
    chk(exp_q.size() == 0, "R12 codes seen", exp_q.size(), 0);

    report();
  end
endmodule